// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a 24-bit periodic down-counter meant to pace an operating-system scheduler. Software reaches it through a simple word-addressed read/write port with four 32-bit registers: a control word, a reload value, the live count and a read-only calibration word. While it is enabled the counter steps down once per selected tick. The tick is either every cycle of the processor clock or each rising edge of an external reference signal. When it steps from 1 to 0 it latches a sticky expiry flag and, if interrupts are enabled, pulses an interrupt request. On the following tick it refills from the reload register.

The intended programming sequence has three steps. Software writes the reload value first, then writes anything to the current-value register to zero the count. It then enables the counter, the interrupt and the clock source in one full-word write to control, so the first tick loads a fresh period. Reading the control word returns the expiry flag and clears it. The calibration word reports a fixed 10 ms reload value and two quality flags, and these come from module parameters.

Top module: `tick_timer`

## Requirements
- R1: Word index 0 is control, 1 is reload, 2 is current value and 3 is calibration. After reset, control, reload and current value read as 0, `irq` is low and `bus_rdata` is 0.
- R2: In the control word, bit 0 enables counting, bit 1 enables the interrupt request and bit 2 selects the tick source (1 = every processor clock cycle, 0 = external reference). While bit 0 is 0 the count does not change except by a current-value write.
- R3: Control bit 16 is the expiry flag. It is set when the count steps from 1 to 0, a control read returns it and clears it, and a flag set in the same cycle as a control read survives that read.
- R4: When the count is 0, an enabled tick loads the 24-bit reload value held in reload bits 23:0. Reload bits 31:24 read as 0.
- R5: A write of any data to the current-value register sets the count to 0 and clears the expiry flag.
- R6: `irq` is high for exactly one cycle, in the cycle after the 1-to-0 step, and only if control bit 1 was set. With bit 1 clear the flag still sets but `irq` stays low.
- R7: Each enabled tick lowers a nonzero count by exactly one. In processor-clock mode every cycle is a tick, so after k ticks from 0 with reload N>0 the count is N-((k-1) mod (N+1)).
- R8: In external mode each rising edge of `ext_ref` gives exactly one tick after a two-flop synchroniser, however long the level is held.
- R9: With a reload value of 0 the enabled counter stays at 0, the flag never sets and `irq` stays low.
- R10: The calibration word is read-only: bit 31 is the no-reference flag, bit 30 is the skew flag and bits 23:0 are the 10 ms reload value, all taken from parameters. Writes to it have no effect.
- R11: Read data is registered. `bus_rdata` changes on the clock edge that samples `bus_rd`, holds until the next read, and unused control bits read as 0 whatever was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Word index of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ext_ref | input | 1 | Asynchronous external reference tick |
| irq | output | 1 | One-cycle tick interrupt request |

## Verification
The assertions check several relations on every cycle. A nonzero count drops by one per tick, a disabled count holds, and a current-value write leaves zero with the flag clear. A reload of zero keeps the count at zero, a control read with no tick in flight clears the flag, and `irq` is a single-cycle pulse that only ever comes with the flag set. Some behaviours are only visible in the bench's scenarios and register reads. These include the reload sequence over many periods, the irq count against the number of expiries, and the flag surviving a read on the very cycle it is set. They also include one tick per external edge through the synchroniser, the calibration constant, and masking of reserved bits.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL    = 2'd0,
    REG_RELOAD  = 2'd1,
    REG_CURRENT = 2'd2,
    REG_CALIB   = 2'd3
  } reg_sel_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_IE_BIT   = 1;
  localparam int CTRL_SRC_BIT  = 2;
  localparam int CTRL_FLAG_BIT = 16;
endpackage

// File: rtl/tick_refsync.sv
module tick_refsync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  output logic ref_rise
);
  logic [SYNC_STAGES:0] shift_q;

  always_ff @(posedge clk) begin
    if (rst) shift_q <= '0;
    else     shift_q <= {shift_q[SYNC_STAGES-1:0], ref_in};
  end

  // edge seen between the last synchroniser flop and the history flop
  assign ref_rise = shift_q[SYNC_STAGES-1] & ~shift_q[SYNC_STAGES];
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             clear,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)             count <= '0;
    else if (clear)      count <= '0;
    else if (tick) begin
      if (count == '0)   count <= reload;
      else               count <= count - ONE;
    end
  end

  assign hit = tick & ~clear & (count == ONE);
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int               DATA_W     = 32,
  parameter int               CNT_W      = 24,
  parameter int               SYNC_STAGES = 2,
  parameter logic             CAL_NOREF  = 1'b0,
  parameter logic             CAL_SKEW   = 1'b0,
  parameter logic [CNT_W-1:0] CAL_TENMS  = CNT_W'(99_999)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_ref,
  output logic              irq
);
  import tick_pkg::*;

  localparam int NOREF_BIT = DATA_W - 1;
  localparam int SKEW_BIT  = DATA_W - 2;

  logic             ctl_en, ctl_ie, ctl_src;
  logic             flag_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cur_count;
  logic             ref_rise;
  logic             tick_en;
  logic             hit;
  logic             irq_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_word;

  logic wr_ctrl, wr_reload, wr_current, rd_ctrl;
  assign wr_ctrl    = bus_wr && (bus_addr == REG_CTRL);
  assign wr_reload  = bus_wr && (bus_addr == REG_RELOAD);
  assign wr_current = bus_wr && (bus_addr == REG_CURRENT);
  assign rd_ctrl    = bus_rd && (bus_addr == REG_CTRL);

  tick_refsync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .ref_in  (ext_ref),
    .ref_rise(ref_rise)
  );

  assign tick_en = ctl_en & (ctl_src | ref_rise);

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick_en),
    .clear (wr_current),
    .reload(reload_q),
    .count (cur_count),
    .hit   (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_en   <= 1'b0;
      ctl_ie   <= 1'b0;
      ctl_src  <= 1'b0;
      reload_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctl_en  <= bus_wdata[CTRL_EN_BIT];
        ctl_ie  <= bus_wdata[CTRL_IE_BIT];
        ctl_src <= bus_wdata[CTRL_SRC_BIT];
      end
      if (wr_reload) reload_q <= bus_wdata[CNT_W-1:0];
    end
  end

  // a new expiry wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)                         flag_q <= 1'b0;
    else if (hit)                    flag_q <= 1'b1;
    else if (rd_ctrl || wr_current)  flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= hit & ctl_ie;
  end

  always_comb begin
    rd_word = '0;
    unique case (bus_addr)
      REG_CTRL: begin
        rd_word[CTRL_EN_BIT]   = ctl_en;
        rd_word[CTRL_IE_BIT]   = ctl_ie;
        rd_word[CTRL_SRC_BIT]  = ctl_src;
        rd_word[CTRL_FLAG_BIT] = flag_q;
      end
      REG_RELOAD:  rd_word[CNT_W-1:0] = reload_q;
      REG_CURRENT: rd_word[CNT_W-1:0] = cur_count;
      default: begin
        rd_word[NOREF_BIT]  = CAL_NOREF;
        rd_word[SKEW_BIT]   = CAL_SKEW;
        rd_word[CNT_W-1:0]  = CAL_TENMS;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_word;
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       bus_addr,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic             irq,
  input logic             ctl_en,
  input logic             tick_en,
  input logic             flag_q,
  input logic [CNT_W-1:0] cur_count,
  input logic [CNT_W-1:0] reload_q
);
  import tick_pkg::*;

  logic cv_wr, ctrl_rd;
  assign cv_wr   = bus_wr && (bus_addr == REG_CURRENT);
  assign ctrl_rd = bus_rd && (bus_addr == REG_CTRL);

  p_hold_when_off_r2: assert property (@(posedge clk) disable iff (rst)
    (!ctl_en && !cv_wr) |=> $stable(cur_count));

  p_read_clears_flag_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrl_rd && !tick_en) |=> !flag_q);

  p_cv_write_zeroes_r5: assert property (@(posedge clk) disable iff (rst)
    cv_wr |=> (cur_count == '0) && !flag_q);

  p_irq_single_r6: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  p_irq_with_flag_r6: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag_q);

  p_step_down_r7: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !cv_wr && cur_count != '0) |=> cur_count == $past(cur_count) - CNT_W'(1));

  p_zero_reload_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (tick_en && cur_count == '0 && reload_q == '0) |=> (cur_count == '0) && !$rose(flag_q));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .irq      (irq),
  .ctl_en   (ctl_en),
  .tick_en  (tick_en),
  .flag_q   (flag_q),
  .cur_count(cur_count),
  .reload_q (reload_q)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] CAL_EXP = 32'hC001_869F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ext_ref = 1'b0;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;
  int irq_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_timer #(
    .CAL_NOREF(1'b1), .CAL_SKEW(1'b1), .CAL_TENMS(24'h01869F)
  ) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_ref(ext_ref), .irq(irq)
  );

  always @(negedge clk) if (!rst && irq) irq_cnt <= irq_cnt + 1;

  function automatic int unsigned exp_cnt(int unsigned r, int unsigned k);
    if (k == 0 || r == 0) return 0;
    return r - ((k - 1) % (r + 1));
  endfunction

  function automatic int unsigned exp_hits(int unsigned r, int unsigned k);
    if (r == 0) return 0;
    return k / (r + 1);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge; the access happens at the next posedge
  task automatic bus_write(logic [1:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic prep(int unsigned r);
    logic [31:0] tmp;
    bus_write(2'd0, 32'h0);
    bus_write(2'd1, r);
    bus_write(2'd2, $urandom);
    bus_read(2'd0, tmp);
  endtask

  task automatic finish_run(string tag, int unsigned r, int unsigned k, bit ie, int base);
    logic [31:0] v;
    int unsigned h;
    h = exp_hits(r, k);
    bus_write(2'd0, 32'h0);
    repeat (2) @(negedge clk);
    bus_read(2'd2, v);
    chk({tag, " R7 count"}, v, exp_cnt(r, k));
    bus_read(2'd0, v);
    chk({tag, " R3 flag read"}, v, (h > 0) ? 32'h0001_0000 : 32'h0);
    bus_read(2'd0, v);
    chk({tag, " R3 flag cleared"}, v, 32'h0);
    bus_read(2'd2, v);
    chk({tag, " R2 count held while off"}, v, exp_cnt(r, k));
    chk({tag, " R6 irq pulses"}, irq_cnt - base, ie ? h : 0);
  endtask

  task automatic run_proc(int unsigned r, int unsigned w, bit ie);
    int base;
    prep(r);
    base = irq_cnt;
    bus_write(2'd0, 32'h5 | (32'(ie) << 1));
    repeat (w) @(negedge clk);
    finish_run("proc", r, w + 1, ie, base);
  endtask

  task automatic run_ext(int unsigned r, int unsigned p);
    int base;
    prep(r);
    base = irq_cnt;
    bus_write(2'd0, 32'h3);
    for (int i = 0; i < p; i++) begin
      ext_ref = 1'b1; repeat (3 + i % 3) @(negedge clk);
      ext_ref = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    finish_run("R8 ext", r, p, 1'b1, base);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdata after reset", bus_rdata, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    bus_read(2'd0, v); chk("R1 control reset", v, 32'h0);
    bus_read(2'd1, v); chk("R1 reload reset", v, 32'h0);
    bus_read(2'd2, v); chk("R1 current reset", v, 32'h0);

    // R10 calibration, write ignored
    bus_read(2'd3, v); chk("R10 calibration", v, CAL_EXP);
    bus_write(2'd3, 32'h0);
    bus_read(2'd3, v); chk("R10 calibration after write", v, CAL_EXP);

    // R11 read data holds; R4 reload upper bits; reserved control bits
    bus_write(2'd1, 32'hFFFF_FFFF);
    bus_read(2'd1, v); chk("R4 reload masked", v, 32'h00FF_FFFF);
    repeat (3) @(negedge clk);
    chk("R11 rdata holds", bus_rdata, 32'h00FF_FFFF);
    bus_write(2'd0, 32'hFFFF_FFF8);
    bus_read(2'd0, v); chk("R11 reserved control bits", v, 32'h0);

    // R3 flag set on the same edge as a control read
    prep(2);
    base = irq_cnt;
    bus_write(2'd0, 32'h7);
    repeat (2) @(negedge clk);
    bus_read(2'd0, v); chk("R3 read on expiry edge", v, 32'h0000_0007);
    bus_write(2'd0, 32'h0);
    bus_read(2'd0, v); chk("R3 flag survives read", v, 32'h0001_0000);
    chk("R6 one irq", irq_cnt - base, 1);

    // R5 current write zeroes and clears flag
    run_proc(3, 10, 1'b0);
    prep(4);
    bus_write(2'd0, 32'h5);
    repeat (7) @(negedge clk);
    bus_write(2'd0, 32'h0);
    bus_write(2'd2, 32'hDEAD_BEEF);
    bus_read(2'd2, v); chk("R5 count zeroed", v, 32'h0);
    bus_read(2'd0, v); chk("R5 flag cleared", v, 32'h0);

    // R9 zero reload
    run_proc(0, 25, 1'b1);

    // R6 no irq with interrupt disabled
    run_proc(1, 9, 1'b0);
    run_proc(1, 9, 1'b1);

    // R7 random processor-clock runs
    for (int it = 0; it < 14; it++)
      run_proc(1 + ($urandom % 12), $urandom % 45, 1'($urandom));

    // R8 external reference
    run_ext(3, 2);
    run_ext(3, 9);
    run_ext(5, 13);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule